// File: doc/BRIEF.md
# CPU-side PRG bank and work-RAM guard

This block sits on the CPU side of a cartridge bank mapper. It watches CPU writes to the upper register space and keeps three switchable 8 KB PRG-ROM bank numbers. It also holds a handful of control bits packed beside those numbers and one protect byte for the external work RAM.

For every CPU address in the $8000-$FFFF range, it forms the PRG-ROM address from a 6-bit bank number and CPU A12:A0. The top 8 KB window is always tied to the last bank of the ROM. For addresses in $6000-$7FFF, it selects the external 8 KB work RAM. It lets a write through only when the protect byte carries the unlock key in its upper nybble and the protect bit of the addressed 2 KB quarter is clear.

The control bits leave the block as plain outputs:
- a sound-off flag;
- two CHR-RAM disable flags, one for each pattern table half;
- an open-collector style pin, driven inverted;
- a second pin, driven directly.

Register writes arrive as a one-cycle write pulse in the system clock domain.

Top module: `prg_bank_guard`

## Requirements
- R1: After synchronous reset, all three bank registers are 0 and snd_off, pin_b, chr_lo_off and chr_hi_off are 0. pin_a_n is 1. The protect byte is 0, so work RAM is read-only.
- R2: A write pulse to any address in $E000-$E7FF loads data bits 5:0 as the bank for $8000-$9FFF and data bit 6 into snd_off. It drives pin_a_n with the inverse of data bit 7.
- R3: A write pulse to any address in $E800-$EFFF loads data bits 5:0 as the bank for $A000-$BFFF. Data bit 6 goes to chr_lo_off and data bit 7 goes to chr_hi_off.
- R4: A write pulse to any address in $F000-$F7FF loads data bits 5:0 as the bank for $C000-$DFFF. Data bit 7 drives pin_b and data bit 6 is ignored.
- R5: CPU addresses $E000-$FFFF always select bank 63, the last bank, whatever has been written.
- R6: rom_addr is the 6-bit bank of the window picked by CPU A14:A13 in bits 18:13, followed by CPU A12:A0 in bits 12:0.
- R7: ram_ce is 1 exactly for CPU addresses $6000-$7FFF, with or without a write pulse, whatever the protect byte holds.
- R8: A write pulse to $F800-$FFFF loads the protect byte. ram_we is 1 only when cpu_we is 1, ram_ce is 1, protect bits 7:4 equal 0100, and protect bit q is 0. Here q is CPU A12:A11, so quarter 0 is $6000-$67FF up to quarter 3 at $7800-$7FFF.
- R9: With any protect byte whose upper nybble is not 0100, or with $4F, no work-RAM quarter is writable.
- R10: Write pulses to addresses outside $E000-$FFFF change no bank register and no control output.
- R11: A register write takes effect at the clock edge that ends the write pulse. ram_we follows cpu_we in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the write pulse is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | One-cycle CPU write pulse |
| rom_addr | output | 19 | PRG-ROM address: bank bits 18:13 and CPU A12:A0 |
| ram_ce | output | 1 | Work-RAM select for $6000-$7FFF |
| ram_we | output | 1 | Work-RAM write enable after the protect rule |
| snd_off | output | 1 | Sound-disable flag |
| chr_lo_off | output | 1 | CHR-RAM disable flag for the lower pattern table |
| chr_hi_off | output | 1 | CHR-RAM disable flag for the upper pattern table |
| pin_a_n | output | 1 | General-purpose pin, inverse of the stored bit |
| pin_b | output | 1 | General-purpose pin, stored bit as is |

## Verification
rom_addr, ram_ce and ram_we are combinational in the address and the stored state, so the bench checks them 1 ns after it drives a new address in the same low phase of the clock. Register contents are due one rising edge after the write pulse. The bench therefore holds each write for exactly one cycle and probes at the following falling edge. The timing rule for pins is shown directly: pin_b is checked before the edge that ends a write, where it must still hold its old value, and again just after that edge, where it must show the new value.

// File: rtl/prgb_pkg.sv
package prgb_pkg;

    localparam int CPU_AW     = 16;
    localparam int DATA_W     = 8;
    localparam int WIN_AW     = 13;              // 8 KB window offset bits
    localparam int GRAIN_AW   = 11;              // 2 KB register/quarter grain
    localparam int HI_W       = CPU_AW - GRAIN_AW;
    localparam int WIN_SEL_W  = 2;
    localparam int NUM_WIN    = 1 << WIN_SEL_W;  // windows in $8000-$FFFF
    localparam int NUM_SW     = NUM_WIN - 1;     // switchable windows
    localparam logic [3:0] GUARD_KEY = 4'b0100;

    // 2 KB slot inside the $E000-$FFFF register page
    typedef enum logic [1:0] {
        SLOT_BANK0 = 2'd0,
        SLOT_BANK1 = 2'd1,
        SLOT_BANK2 = 2'd2,
        SLOT_GUARD = 2'd3
    } slot_e;

    typedef struct packed {
        logic snd_off;
        logic pin_a_lvl;
        logic pin_b_lvl;
        logic chr_lo_off;
        logic chr_hi_off;
    } ctl_t;

    // upper address bits [15:13] select the register page or the RAM page
    function automatic logic in_reg_page(input logic [HI_W-1:0] a_hi);
        return a_hi[HI_W-1 -: 3] == 3'b111;
    endfunction

    function automatic logic in_ram_page(input logic [HI_W-1:0] a_hi);
        return a_hi[HI_W-1 -: 3] == 3'b011;
    endfunction

    function automatic logic guard_open(input logic [DATA_W-1:0] guard,
                                        input logic [1:0] quarter);
        return (guard[DATA_W-1 -: 4] == GUARD_KEY) && !guard[quarter];
    endfunction

endpackage

// File: rtl/prgb_reg_decode.sv
module prgb_reg_decode
    import prgb_pkg::*;
(
    input  logic [HI_W-1:0]   a_hi,
    input  logic              cpu_we,
    output logic [NUM_SW-1:0] bank_ld,
    output logic              guard_ld
);
    logic  page_hit;
    slot_e slot;

    assign page_hit = cpu_we && in_reg_page(a_hi);
    assign slot     = slot_e'(a_hi[1:0]);
    assign guard_ld = page_hit && (slot == SLOT_GUARD);

    for (genvar w = 0; w < NUM_SW; w++) begin : g_ld
        assign bank_ld[w] = page_hit && (a_hi[1:0] == 2'(w));
    end
endmodule

// File: rtl/prgb_reg_file.sv
module prgb_reg_file
    import prgb_pkg::*;
#(
    parameter int BANK_W = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_SW-1:0]             bank_ld,
    input  logic                          guard_ld,
    input  logic [DATA_W-1:0]             wdata,
    output logic [NUM_SW-1:0][BANK_W-1:0] banks,
    output ctl_t                          ctl,
    output logic [DATA_W-1:0]             guard
);
    for (genvar w = 0; w < NUM_SW; w++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst)
                banks[w] <= '0;
            else if (bank_ld[w])
                banks[w] <= wdata[BANK_W-1:0];
        end
    end

    // control bits packed beside each bank number
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else begin
            if (bank_ld[SLOT_BANK0]) begin
                ctl.snd_off   <= wdata[6];
                ctl.pin_a_lvl <= wdata[7];
            end
            if (bank_ld[SLOT_BANK1]) begin
                ctl.chr_lo_off <= wdata[6];
                ctl.chr_hi_off <= wdata[7];
            end
            if (bank_ld[SLOT_BANK2])
                ctl.pin_b_lvl <= wdata[7];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            guard <= '0;
        else if (guard_ld)
            guard <= wdata;
    end
endmodule

// File: rtl/prgb_bank_map.sv
module prgb_bank_map
    import prgb_pkg::*;
#(
    parameter int BANK_W = 6,
    localparam int ROM_AW = BANK_W + WIN_AW
) (
    input  logic [WIN_AW+WIN_SEL_W-1:0]   addr,
    input  logic [NUM_SW-1:0][BANK_W-1:0] banks,
    output logic [ROM_AW-1:0]             rom_addr
);
    logic [BANK_W-1:0]    win_bank [NUM_WIN];
    logic [WIN_SEL_W-1:0] win_idx;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        if (w < NUM_SW) begin : g_sw
            assign win_bank[w] = banks[w];
        end else begin : g_fixed
            assign win_bank[w] = '1;    // last bank of the ROM
        end
    end

    assign win_idx  = addr[WIN_AW +: WIN_SEL_W];
    assign rom_addr = {win_bank[win_idx], addr[WIN_AW-1:0]};
endmodule

// File: rtl/prgb_ram_guard.sv
module prgb_ram_guard
    import prgb_pkg::*;
(
    input  logic [HI_W-1:0]   a_hi,
    input  logic              cpu_we,
    input  logic [DATA_W-1:0] guard,
    output logic              ram_ce,
    output logic              ram_we
);
    logic [1:0] quarter;

    assign quarter = a_hi[1:0];
    assign ram_ce  = in_ram_page(a_hi);
    assign ram_we  = ram_ce && cpu_we && guard_open(guard, quarter);
endmodule

// File: rtl/prg_bank_guard.sv
module prg_bank_guard
    import prgb_pkg::*;
#(
    parameter int BANK_W = 6,
    localparam int ROM_AW = BANK_W + WIN_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_we,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              ram_ce,
    output logic              ram_we,
    output logic              snd_off,
    output logic              chr_lo_off,
    output logic              chr_hi_off,
    output logic              pin_a_n,
    output logic              pin_b
);
    logic [NUM_SW-1:0]             bank_ld;
    logic                          guard_ld;
    logic [NUM_SW-1:0][BANK_W-1:0] banks;
    ctl_t                          ctl;
    logic [DATA_W-1:0]             guard;

    prgb_reg_decode u_decode (
        .a_hi     (cpu_addr[CPU_AW-1:GRAIN_AW]),
        .cpu_we   (cpu_we),
        .bank_ld  (bank_ld),
        .guard_ld (guard_ld)
    );

    prgb_reg_file #(.BANK_W(BANK_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bank_ld  (bank_ld),
        .guard_ld (guard_ld),
        .wdata    (cpu_wdata),
        .banks    (banks),
        .ctl      (ctl),
        .guard    (guard)
    );

    prgb_bank_map #(.BANK_W(BANK_W)) u_map (
        .addr     (cpu_addr[WIN_AW+WIN_SEL_W-1:0]),
        .banks    (banks),
        .rom_addr (rom_addr)
    );

    prgb_ram_guard u_guard (
        .a_hi     (cpu_addr[CPU_AW-1:GRAIN_AW]),
        .cpu_we   (cpu_we),
        .guard    (guard),
        .ram_ce   (ram_ce),
        .ram_we   (ram_we)
    );

    assign snd_off    = ctl.snd_off;
    assign chr_lo_off = ctl.chr_lo_off;
    assign chr_hi_off = ctl.chr_hi_off;
    assign pin_a_n    = ~ctl.pin_a_lvl;
    assign pin_b      = ctl.pin_b_lvl;
endmodule

// File: rtl/prg_bank_guard_chk.sv
module prg_bank_guard_chk #(
    parameter int ROM_AW = 19
) (
    input logic              clk,
    input logic              rst,
    input logic [15:0]       cpu_addr,
    input logic [7:0]        cpu_wdata,
    input logic              cpu_we,
    input logic [ROM_AW-1:0] rom_addr,
    input logic              ram_ce,
    input logic              ram_we,
    input logic              snd_off,
    input logic              chr_lo_off,
    input logic              chr_hi_off,
    input logic              pin_a_n,
    input logic              pin_b
);
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!snd_off && pin_a_n && !pin_b && !chr_lo_off && !chr_hi_off));

    p_snd_load_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr[15:11] == 5'b11100) |=>
        (snd_off == $past(cpu_wdata[6]) && pin_a_n == !$past(cpu_wdata[7])));

    p_chr_load_r3: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr[15:11] == 5'b11101) |=>
        (chr_lo_off == $past(cpu_wdata[6]) && chr_hi_off == $past(cpu_wdata[7])));

    p_pin_b_load_r4: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr[15:11] == 5'b11110) |=> (pin_b == $past(cpu_wdata[7])));

    p_fixed_top_r5: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:13] == 3'b111) |-> (rom_addr[ROM_AW-1:13] == '1));

    p_ram_ce_page_r7: assert property (@(posedge clk) disable iff (rst)
        ram_ce |-> (cpu_addr[15:13] == 3'b011));

    p_ram_we_gate_r8: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (ram_ce && cpu_we));

    p_ctl_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!cpu_we || cpu_addr[15:13] != 3'b111) |=>
        $stable({snd_off, pin_a_n, pin_b, chr_lo_off, chr_hi_off}));
endmodule

bind prg_bank_guard prg_bank_guard_chk #(.ROM_AW(ROM_AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_we     (cpu_we),
    .rom_addr   (rom_addr),
    .ram_ce     (ram_ce),
    .ram_we     (ram_we),
    .snd_off    (snd_off),
    .chr_lo_off (chr_lo_off),
    .chr_hi_off (chr_hi_off),
    .pin_a_n    (pin_a_n),
    .pin_b      (pin_b)
);

// File: tb/prg_bank_guard_bench.sv
`timescale 1ns/1ps
module prg_bank_guard_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        cpu_we = 1'b0;
    logic [18:0] rom_addr;
    logic        ram_ce, ram_we, snd_off, chr_lo_off, chr_hi_off, pin_a_n, pin_b;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    prg_bank_guard u_prg_bank_guard (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .rom_addr(rom_addr), .ram_ce(ram_ce), .ram_we(ram_we),
        .snd_off(snd_off), .chr_lo_off(chr_lo_off), .chr_hi_off(chr_hi_off),
        .pin_a_n(pin_a_n), .pin_b(pin_b)
    );

    typedef struct packed {
        logic [15:0] waddr;
        logic [7:0]  wdata;
        logic [15:0] paddr;
        logic [5:0]  bank;
        logic        snd;
        logic        pa_n;
        logic        pb;
        logic        lo;
        logic        hi;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 14;
    // expected values are cumulative over the table
    localparam vec_t VECS [NVEC] = '{
        '{16'hE000, 8'h85, 16'h8123, 6'd5,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
        '{16'hE7FF, 8'h6A, 16'h9FFF, 6'd42, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
        '{16'hE800, 8'hC3, 16'hA000, 6'd3,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd3},  // R3
        '{16'hEFFF, 8'h3F, 16'hBFFF, 6'd63, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3},  // R3
        '{16'hF000, 8'hC7, 16'hC010, 6'd7,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd4},  // R4
        '{16'hF7FF, 8'h11, 16'hDFFF, 6'd17, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
        '{16'h8000, 8'hFF, 16'h8000, 6'd42, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd10}, // R10
        '{16'hDFFF, 8'h00, 16'hC000, 6'd17, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd10}, // R10
        '{16'hF000, 8'h02, 16'hE456, 6'd63, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
        '{16'h5800, 8'hFF, 16'hC000, 6'd2,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd10}, // R10
        '{16'hF800, 8'h40, 16'hA000, 6'd63, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd10}, // R10
        '{16'h7000, 8'hFF, 16'h8000, 6'd42, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd10}, // R10
        '{16'hE800, 8'h40, 16'hA7FF, 6'd0,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd3},  // R3
        '{16'hE000, 8'h00, 16'hFFFF, 6'd63, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd5}   // R5
    };

    localparam int NKEY = 11;
    localparam logic [7:0] KEYS [NKEY] = '{
        8'h40, 8'h41, 8'h42, 8'h44, 8'h48, 8'h4E, 8'h4F, 8'h50, 8'h04, 8'hC0, 8'h00
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_we    = 1'b1;
        @(negedge clk);
        cpu_we    = 1'b0;
    endtask

    task automatic probe(input logic [15:0] a);
        cpu_addr = a;
        #1;
    endtask

    task automatic check_reset_state(input string tag);
        probe(16'h8000); chk({tag, " bank8000"}, 32'(rom_addr[18:13]), 32'd0);
        probe(16'hA000); chk({tag, " bankA000"}, 32'(rom_addr[18:13]), 32'd0);
        probe(16'hC000); chk({tag, " bankC000"}, 32'(rom_addr[18:13]), 32'd0);
        chk({tag, " ctl"}, 32'({snd_off, pin_a_n, pin_b, chr_lo_off, chr_hi_off}),
            32'b01000);
        cpu_we = 1'b1;
        probe(16'h6000);
        chk({tag, " ram locked"}, 32'(ram_we), 32'd0);
        cpu_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_reset_state("R1 reset");

        // table walk: R2 R3 R4 R5 R6 R10
        for (int i = 0; i < NVEC; i++) begin
            do_write(VECS[i].waddr, VECS[i].wdata);
            probe(VECS[i].paddr);
            chk($sformatf("R%0d vec%0d bank", VECS[i].req, i),
                32'(rom_addr[18:13]), 32'(VECS[i].bank));
            chk($sformatf("R6 vec%0d offset", i),
                32'(rom_addr[12:0]), 32'(VECS[i].paddr[12:0]));
            chk($sformatf("R%0d vec%0d ctl", VECS[i].req, i),
                32'({snd_off, pin_a_n, pin_b, chr_lo_off, chr_hi_off}),
                32'({VECS[i].snd, VECS[i].pa_n, VECS[i].pb, VECS[i].lo, VECS[i].hi}));
        end

        // R11: pin_b changes only at the edge that ends the write
        @(negedge clk);
        cpu_addr  = 16'hF400;
        cpu_wdata = 8'h80;
        cpu_we    = 1'b1;
        #1 chk("R11 before edge", 32'(pin_b), 32'd0);
        @(posedge clk);
        #1 chk("R11 after edge", 32'(pin_b), 32'd1);
        @(negedge clk);
        cpu_we = 1'b0;

        // R7: RAM select by address only
        probe(16'h5FFF); chk("R7 below", 32'(ram_ce), 32'd0);
        probe(16'h8000); chk("R7 above", 32'(ram_ce), 32'd0);
        probe(16'h6000); chk("R7 read sel", 32'({ram_ce, ram_we}), 32'b10);

        // R8 R9: keyed protect per quarter
        for (int k = 0; k < NKEY; k++) begin
            do_write(16'hF800 + 16'(k), KEYS[k]);
            for (int q = 0; q < 4; q++) begin
                logic exp_we;
                exp_we = (KEYS[k][7:4] == 4'b0100) && !KEYS[k][q];
                @(negedge clk);
                cpu_addr = 16'h6000 + 16'(q) * 16'h0800 + 16'h0123;
                cpu_we   = 1'b1;
                #1;
                chk($sformatf("R8 key %0h q%0d ce", KEYS[k], q), 32'(ram_ce), 32'd1);
                chk($sformatf("%s key %0h q%0d we",
                              (KEYS[k][7:4] == 4'b0100 && KEYS[k] != 8'h4F) ? "R8" : "R9",
                              KEYS[k], q), 32'(ram_we), 32'(exp_we));
                cpu_we = 1'b0;
                #1 chk($sformatf("R11 key %0h q%0d we drop", KEYS[k], q), 32'(ram_we), 32'd0);
            end
        end

        // R1: reset again after activity
        do_write(16'hF800, 8'h40);
        do_write(16'hE000, 8'hC9);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_reset_state("R1 rereset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule